// File: doc/BRIEF.md
# Synchronous Serial Shift Port

The block is a half-duplex synchronous shift port. It drives a shift clock and one data line whose driver it enables only while sending. Writing a byte into the transmit buffer shifts that byte out, least significant bit first. Holding the receive enable high while the port is idle, with no unread received byte, shifts eight bits in from the data input. Each direction has its own completion flag, and each flag stays set until it is cleared.

A speed input selects one of two fixed bit periods, measured in cycles of the block clock. In the slow setting a bit lasts 12 cycles. Output data changes 10 cycles before the shift clock rises and holds for 2 cycles after it. In the fast setting a bit lasts 4 cycles, with 3 cycles of setup and 1 cycle of hold. The block samples input data on the same clock edge that raises the shift clock. The speed is captured when a transfer starts.

Top module: `ssp_port`

## Requirements
- R1: After reset, `sclk_o` is 1, `sd_oe_o` is 0, both done flags are 0 and `rx_data_o` is 0.
- R2: With `fast_i`=0 at the start, a bit lasts 12 clock cycles. The shift clock is low for the first 10 of them and high for the last 2, and data for a bit changes only in its first cycle.
- R3: With `fast_i`=1 at the start, a bit lasts 4 clock cycles. The shift clock is low for the first 3 and high for the last 1.
- R4: A `wr_en_i` pulse while idle sends `wr_data_i` over 8 bit periods, bit 0 first. `sd_o` carries the bit and `sd_oe_o` is 1 for the whole transfer. Afterwards `sclk_o` returns to 1 and `sd_oe_o` to 0.
- R5: `tx_done_o` goes to 1 in the same cycle that the eighth shift clock rise appears. It stays 1 until `clr_tx_i` is pulsed.
- R6: With `rx_en_i`=1 while idle and `rx_done_o`=0, a reception starts. During it `sd_oe_o` stays 0, and `sd_i` is sampled at each clock edge that raises `sclk_o`. The first sample becomes bit 0.
- R7: `rx_done_o` goes to 1 and `rx_data_o` takes the received byte together, with the eighth shift clock rise. `rx_data_o` then holds its value, and `rx_done_o` stays 1 until `clr_rx_i` is pulsed.
- R8: A `wr_en_i` pulse during a transfer has no effect on the byte in flight or on the timing.
- R9: Changing `fast_i` during a transfer has no effect on that transfer's timing.
- R10: When `wr_en_i` and a reception start condition coincide, the transmission wins.
- R11: While `rx_done_o`=1, `rx_en_i`=1 does not start a reception, and `sclk_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Speed select: 0 = 12-cycle bit, 1 = 4-cycle bit |
| wr_en_i | input | 1 | Transmit buffer write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| clr_tx_i | input | 1 | Clears the transmit done flag |
| clr_rx_i | input | 1 | Clears the receive done flag |
| tx_done_o | output | 1 | Transmit completed |
| rx_done_o | output | 1 | Receive completed |
| rx_data_o | output | 8 | Last received byte |
| sclk_o | output | 1 | Shift clock, idles high |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The assertions assume that the two clear strobes are never pulsed in the same cycle as the completion they would clear. They also assume that `rx_data_o` changes only at a completion. Both hold only while software clears a flag after it has seen it set. The bench issues clears only once a transfer has finished and its flag has been observed. The bench acts as the remote sender. It changes `sd_i` only at the start of each bit and puts a wrong value on the line late in the slow bit period, so a sample taken at the wrong edge would capture it. Every stimulus change is driven on the falling clock edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } ssp_dir_e;

  localparam int unsigned FLAG_TX = 0;
  localparam int unsigned FLAG_RX = 1;
  localparam int unsigned N_FLAGS = 2;
endpackage

// File: rtl/ssp_timer.sv
module ssp_timer #(
  parameter int unsigned SLOW_DIV  = 12,
  parameter int unsigned FAST_DIV  = 4,
  parameter int unsigned SLOW_LEAD = 10,
  parameter int unsigned FAST_LEAD = 3,
  parameter int unsigned NBITS     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  output logic busy_o,
  output logic sclk_o,
  output logic sample_o,
  output logic bit_end_o,
  output logic last_bit_o
);
  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int unsigned PH_W    = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam int unsigned BIT_W   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [PH_W-1:0]  SLOW_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0]  FAST_LAST = PH_W'(FAST_DIV - 1);
  localparam logic [PH_W-1:0]  SLOW_RISE = PH_W'(SLOW_LEAD);
  localparam logic [PH_W-1:0]  FAST_RISE = PH_W'(FAST_LEAD);
  localparam logic [PH_W-1:0]  SLOW_SMP  = PH_W'(SLOW_LEAD - 1);
  localparam logic [PH_W-1:0]  FAST_SMP  = PH_W'(FAST_LEAD - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(NBITS - 1);

  logic              busy_q, fast_q;
  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [PH_W-1:0]   ph_last, ph_rise, ph_smp;

  // speed is frozen for the whole transfer
  assign ph_last = fast_q ? FAST_LAST : SLOW_LAST;
  assign ph_rise = fast_q ? FAST_RISE : SLOW_RISE;
  assign ph_smp  = fast_q ? FAST_SMP  : SLOW_SMP;

  assign busy_o     = busy_q;
  assign sclk_o     = !busy_q || (ph_q >= ph_rise);
  assign sample_o   = busy_q && (ph_q == ph_smp);
  assign bit_end_o  = busy_q && (ph_q == ph_last);
  assign last_bit_o = (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fast_q <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        fast_q <= fast_i;
        ph_q   <= '0;
        bit_q  <= '0;
      end
    end else if (ph_q == ph_last) begin
      ph_q <= '0;
      if (bit_q == LAST_BIT) busy_q <= 1'b0;
      else                   bit_q  <= bit_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         tx_shift_i,
  input  logic         rx_shift_i,
  input  logic         sd_i,
  output logic         lsb_o,
  output logic [W-1:0] rx_next_o
);
  logic [W-1:0] sh_q;

  assign lsb_o     = sh_q[0];
  assign rx_next_o = {sd_i, sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sh_q <= '0;
    else if (load_i)     sh_q <= load_data_i;
    else if (tx_shift_i) sh_q <= {1'b0, sh_q[W-1:1]};
    else if (rx_shift_i) sh_q <= rx_next_o;
  end
endmodule

// File: rtl/ssp_flag.sv
module ssp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;  // set wins over clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SLOW_DIV  = 12,
  parameter int unsigned FAST_DIV  = 4,
  parameter int unsigned SLOW_LEAD = 10,
  parameter int unsigned FAST_LEAD = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rx_en_i,
  input  logic              clr_tx_i,
  input  logic              clr_rx_i,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i
);
  logic busy, sample, bit_end, last_bit;
  logic start_tx, start_rx, finish;
  logic lsb;
  logic [DATA_W-1:0] rx_next;
  ssp_dir_e dir_q;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

  // transmit write outranks a receive start
  assign start_tx = !busy && wr_en_i;
  assign start_rx = !busy && !wr_en_i && rx_en_i && !flag_q[FLAG_RX];
  assign finish   = sample && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= DIR_TX;
    else if (start_tx) dir_q <= DIR_TX;
    else if (start_rx) dir_q <= DIR_RX;
  end

  ssp_timer #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .SLOW_LEAD(SLOW_LEAD),
    .FAST_LEAD(FAST_LEAD),
    .NBITS    (DATA_W)
  ) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_tx || start_rx),
    .fast_i    (fast_i),
    .busy_o    (busy),
    .sclk_o    (sclk_o),
    .sample_o  (sample),
    .bit_end_o (bit_end),
    .last_bit_o(last_bit)
  );

  ssp_shifter #(.W(DATA_W)) shifter_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_tx),
    .load_data_i(wr_data_i),
    .tx_shift_i (bit_end && dir_q == DIR_TX),
    .rx_shift_i (sample && dir_q == DIR_RX),
    .sd_i       (sd_i),
    .lsb_o      (lsb),
    .rx_next_o  (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rx_data_o <= '0;
    else if (finish && dir_q == DIR_RX)  rx_data_o <= rx_next;
  end

  assign flag_set[FLAG_TX] = finish && dir_q == DIR_TX;
  assign flag_set[FLAG_RX] = finish && dir_q == DIR_RX;
  assign flag_clr[FLAG_TX] = clr_tx_i;
  assign flag_clr[FLAG_RX] = clr_rx_i;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    ssp_flag flag_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .q_o   (flag_q[g])
    );
  end

  assign tx_done_o = flag_q[FLAG_TX];
  assign rx_done_o = flag_q[FLAG_RX];
  assign sd_oe_o   = busy && dir_q == DIR_TX;
  assign sd_o      = sd_oe_o && lsb;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_tx_i,
  input logic              clr_rx_i,
  input logic              tx_done_o,
  input logic              rx_done_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              sclk_o,
  input logic              sd_o,
  input logic              sd_oe_o
);
  // R2: data is stable while the shift clock stays high during a send
  p_hold_while_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && sclk_o && $past(sd_oe_o) && $past(sclk_o)) |-> $stable(sd_o));

  // R4: the driver releases only with the shift clock high
  p_release_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sd_oe_o) |-> sclk_o);

  // R5: transmit flag rises together with a shift clock rise while driving
  p_tx_flag_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> ($rose(sclk_o) && sd_oe_o));

  // R5: transmit flag is sticky
  p_tx_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o && !clr_tx_i) |=> tx_done_o);

  // R6: receive completes without driving the line
  p_rx_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> ($rose(sclk_o) && !sd_oe_o));

  // R7: receive flag is sticky
  p_rx_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !clr_rx_i) |=> rx_done_o);

  // R7: received byte changes only at a completion
  p_rx_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> $rose(rx_done_o));
endmodule

bind ssp_port ssp_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_tx_i (clr_tx_i),
  .clr_rx_i (clr_rx_i),
  .tx_done_o(tx_done_o),
  .rx_done_o(rx_done_o),
  .rx_data_o(rx_data_o),
  .sclk_o   (sclk_o),
  .sd_o     (sd_o),
  .sd_oe_o  (sd_oe_o)
);

// File: tb/ssp_port_tb_top.sv
module ssp_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast = 1'b0, wr_en = 1'b0, rx_en = 1'b0, clr_tx = 1'b0, clr_rx = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sd_in = 1'b0;
  logic       tx_done, rx_done, sclk, sd_out, sd_oe;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ssp_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fast_i(fast), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rx_en_i(rx_en), .clr_tx_i(clr_tx), .clr_rx_i(clr_rx), .tx_done_o(tx_done),
    .rx_done_o(rx_done), .rx_data_o(rx_data), .sclk_o(sclk), .sd_o(sd_out),
    .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    check(sclk == 1'b1 && sd_oe == 1'b0, "R1 idle lines", {sclk, sd_oe}, 2'b10);
    check(!tx_done && !rx_done, "R1 flags", {tx_done, rx_done}, 0);
    check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
  endtask

  // send one byte; disturb writes a new byte and flips speed mid-transfer
  task automatic t_tx(input logic [7:0] data, input bit spd, input bit disturb, input bit with_rx);
    int per = spd ? 4 : 12;
    int lead = spd ? 3 : 10;
    int clk_err = 0, dat_err = 0, oe_err = 0, flag_err = 0;
    string rq = spd ? "R3" : "R2";
    @(negedge clk);
    fast = spd; wr_en = 1'b1; wr_data = data; rx_en = with_rx;
    @(posedge clk);
    for (int i = 0; i <= 8 * per; i++) begin
      @(negedge clk);
      if (i == 0) begin wr_en = 1'b0; rx_en = 1'b0; end
      if (i < 8 * per) begin
        if (sclk !== ((i % per) >= lead)) clk_err++;
        if (sd_out !== data[i / per]) dat_err++;
        if (sd_oe !== 1'b1) oe_err++;
      end else begin
        if (sclk !== 1'b1) clk_err++;
        if (sd_oe !== 1'b0) oe_err++;
      end
      if (tx_done !== (i >= 7 * per + lead)) flag_err++;
      if (disturb && i == 5) begin wr_en = 1'b1; wr_data = ~data; fast = ~spd; end
      if (disturb && i == 6) wr_en = 1'b0;
    end
    fast = spd;
    check(clk_err == 0, disturb ? "R9 shift clock timing" : rq, clk_err, 0);
    check(dat_err == 0, disturb ? "R8 data bits" : "R4 data bits", dat_err, 0);
    check(oe_err == 0, with_rx ? "R10 write wins" : "R4 output enable", oe_err, 0);
    check(flag_err == 0, "R5 tx_done timing", flag_err, 0);
    repeat (5) @(negedge clk);
    check(tx_done == 1'b1 && sclk == 1'b1, "R5 flag sticky, no restart", {tx_done, sclk}, 2'b11);
    clr_tx = 1'b1;
    @(negedge clk);
    clr_tx = 1'b0;
    check(tx_done == 1'b0, "R5 clear", tx_done, 0);
  endtask

  task automatic t_rx(input logic [7:0] bits, input bit spd, input bit disturb);
    int per = spd ? 4 : 12;
    int lead = spd ? 3 : 10;
    int clk_err = 0, oe_err = 0, flag_err = 0;
    @(negedge clk);
    fast = spd; rx_en = 1'b1; sd_in = bits[0];
    @(posedge clk);
    for (int i = 0; i <= 8 * per; i++) begin
      @(negedge clk);
      if (i < 8 * per) begin
        // sender: new bit at start of period, junk late in the period
        sd_in = ((i % per) >= lead + 1) ? ~bits[i / per] : bits[i / per];
        if (sclk !== ((i % per) >= lead)) clk_err++;
      end else if (sclk !== 1'b1) clk_err++;
      if (sd_oe !== 1'b0) oe_err++;
      if (rx_done !== (i >= 7 * per + lead)) flag_err++;
      if (i == 7 * per + lead) check(rx_data == bits, "R7 data with flag", rx_data, bits);
      if (disturb && i == 4) begin wr_en = 1'b1; wr_data = 8'hFF; fast = ~spd; end
      if (disturb && i == 5) wr_en = 1'b0;
    end
    fast = spd;
    check(clk_err == 0, disturb ? "R9 rx timing" : (spd ? "R3 rx" : "R2 rx"), clk_err, 0);
    check(oe_err == 0, disturb ? "R8 write ignored in rx" : "R6 no drive", oe_err, 0);
    check(flag_err == 0, "R7 rx_done timing", flag_err, 0);
    check(rx_data == bits, "R6 received byte", rx_data, bits);
  endtask

  task automatic t_rx_blocked();
    int hi_err = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sd_in = i[0];
      if (sclk !== 1'b1 || sd_oe !== 1'b0) hi_err++;
    end
    check(hi_err == 0, "R11 no restart while rx_done", hi_err, 0);
    check(rx_done == 1'b1, "R7 rx_done sticky", rx_done, 1);
    rx_en = 1'b0;
    clr_rx = 1'b1;
    @(negedge clk);
    clr_rx = 1'b0;
    check(rx_done == 1'b0, "R7 clear", rx_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx(8'hA5, 1'b0, 1'b0, 1'b0);
    t_tx(8'h3C, 1'b1, 1'b1, 1'b0);
    t_tx(8'h81, 1'b0, 1'b1, 1'b0);
    t_rx(8'h5A, 1'b0, 1'b0);
    t_rx_blocked();
    t_rx(8'hC3, 1'b1, 1'b1);
    rx_en = 1'b1;
    t_rx_blocked();
    t_tx(8'h96, 1'b1, 1'b0, 1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule